// File: doc/BRIEF.md
# Dual-Port Two-Beat Burst SRAM

This block is a synchronous on-chip memory with one write port and one read port that run at the same time. Every access moves a pair of words. The write port takes its second word and its address half a cycle after its first word. The read port delivers its two words on consecutive half-cycles. The storage is two equal halves. One address picks a pair: the first beat lives in the even half and the second in the odd half.

Both edges of the interface clock are modelled on a single fast clock `clk`. A phase flag alternates between phase A (the rising edge of the positive input clock) and phase B (the rising edge of the complementary clock). Each `clk` edge is one half-cycle, and a full interface cycle is two `clk` edges.

Neither port can be stalled. Commands are accepted whenever a select is low at a phase-A edge. Read data is valid for exactly the two half-cycles in which `q_vld` is high, and the consumer must take it then.

Top module: `burst_sram`

## Requirements
- R1: A write is started only when `wr_sel_n` is 0 at a phase-A edge. When it is 1 there, the data, mask and address of that cycle change nothing in storage.
- R2: For a write, the address is taken from the shared `addr` bus at the phase-B edge that follows. For a read, the address is taken from `addr` at the phase-A edge.
- R3: The first write word is captured at the phase-A edge and stored in the even half. The second word is captured at the phase-B edge and stored in the odd half.
- R4: `lane_we_n[n]` guards data bits [9n+8:9n] and is active low. It is sampled on the same edge as the beat it qualifies, and a lane whose select is 1 keeps its old contents.
- R5: A read is started only when `rd_sel_n` is 0 at a phase-A edge; a low level at a phase-B edge starts nothing. Every read returns exactly two words, the even word first and then the odd word.
- R6: The first beat of a read is visible after the third `clk` edge following the command edge, and the second beat after the fourth. Reads issued in consecutive cycles stream out without a gap.
- R7: A read already in flight always completes. When no beat is due, `q_vld` is 0 and `q` reads as zero, which is the released (high-impedance) bus state.
- R8: A read and a write to the same pair accepted in the same cycle return the newly written lanes. A write accepted in a later cycle is not visible to that read.
- R9: `half` is 0 before every phase-A edge and 1 before every phase-B edge, and it toggles on every `clk` edge.
- R10: During reset `q_vld`, `q` and `half` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; each edge is one half-cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_sel_n | input | 1 | Write select, active low, sampled at phase A |
| rd_sel_n | input | 1 | Read select, active low, sampled at phase A |
| addr | input | AW | Shared address: read at phase A, write at phase B |
| wdata | input | DW | Write word; first beat at phase A, second at phase B |
| lane_we_n | input | LANES | Active-low lane write selects for the current beat |
| q | output | DW | Read beat; zero when released |
| q_vld | output | 1 | Read beat valid (output drive enable) |
| half | output | 1 | Current phase: 0 = phase A next, 1 = phase B next |

## Verification
The bench builds the block with AW=3, DW=36 and LANES=4. This gives 8 word pairs and 16 lane-mask patterns per beat, so every pair can be filled and read back. Every pair is also written under all 16 first-beat masks, each with the complementary second-beat mask, while the same pair is read in the same cycle. Every half-cycle of the output is compared against a schedule computed from a reference model. This covers both beats of every read and every idle half-cycle in which the bus must be released.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;
endpackage

// File: rtl/burst_sram_bank.sv
module burst_sram_bank #(
  parameter int AW    = 4,
  parameter int DW    = 36,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wmask_n,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / LANES;

  logic [DW-1:0] mem [DEPTH];

  // Lane-masked write; unselected lanes hold their value.
  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wmask_n[l]) mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/burst_sram_wr_capture.sv
module burst_sram_wr_capture
  import burst_sram_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 36,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           ph,
  input  logic             wr_sel_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] lane_we_n,
  output logic             commit,
  output logic [AW-1:0]    c_addr,
  output logic [DW-1:0]    c_d0,
  output logic [LANES-1:0] c_m0,
  output logic [DW-1:0]    c_d1,
  output logic [LANES-1:0] c_m1
);
  logic             pend;
  logic [DW-1:0]    d0_q;
  logic [LANES-1:0] m0_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      d0_q <= '0;
      m0_q <= '1;
    end else if (ph == PH_A) begin
      pend <= !wr_sel_n;
      d0_q <= wdata;
      m0_q <= lane_we_n;
    end else begin
      pend <= 1'b0;
    end
  end

  // Second beat and address come straight from the bus at phase B.
  assign commit = pend && (ph == PH_B);
  assign c_addr = addr;
  assign c_d0   = d0_q;
  assign c_m0   = m0_q;
  assign c_d1   = wdata;
  assign c_m1   = lane_we_n;

  // R1: a commit happens only after a select seen low one edge earlier
  a_r1_commit_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(wr_sel_n) == 1'b0));
  // R3: commits only occur on phase-B edges, directly after a phase-A edge
  a_r3_commit_on_b: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (ph == PH_A));
endmodule

// File: rtl/burst_sram_rd_pipe.sv
module burst_sram_rd_pipe
  import burst_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        ph,
  input  logic          rd_sel_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] raddr,
  input  logic [DW-1:0] even_q,
  input  logic [DW-1:0] odd_q,
  output logic [DW-1:0] q,
  output logic          q_vld
);
  logic          s1_v, s2_v, sec;
  logic [AW-1:0] s1_a, s2_a;
  logic [DW-1:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      s1_a  <= '0;
      s2_a  <= '0;
      sec   <= 1'b0;
      hold  <= '0;
      q     <= '0;
      q_vld <= 1'b0;
    end else if (ph == PH_A) begin
      s1_v <= !rd_sel_n;
      s1_a <= addr;
      s2_v <= s1_v;
      s2_a <= s1_a;
      sec  <= 1'b0;
      if (sec) begin
        q     <= hold;
        q_vld <= 1'b1;
      end else begin
        q     <= '0;
        q_vld <= 1'b0;
      end
    end else begin
      sec <= s2_v;
      if (s2_v) begin
        q     <= even_q;
        hold  <= odd_q;
        q_vld <= 1'b1;
      end else begin
        q     <= '0;
        q_vld <= 1'b0;
      end
    end
  end

  assign raddr = s2_a;

  // R6: first beat visible after the third edge following the command
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_A && !rd_sel_n) |-> ##4 q_vld);
  // R5: every burst lasts at least two half-cycles
  a_r5_two_beats: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_vld) |=> q_vld);
  // R9: a burst begins only after a phase-B edge
  a_r9_burst_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_vld) |-> (ph == PH_A));
  // R7: no read in two consecutive phase-A windows leaves the bus released
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_A && rd_sel_n && $past(rd_sel_n, 2)) |-> ##2 !q_vld);
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 36,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel_n,
  input  logic             rd_sel_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] lane_we_n,
  output logic [DW-1:0]    q,
  output logic             q_vld,
  output logic             half
);
  phase_e ph;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= PH_A;
    else        ph <= (ph == PH_A) ? PH_B : PH_A;
  end
  assign half = (ph == PH_B);

  logic             commit;
  logic [AW-1:0]    c_addr, raddr;
  logic [DW-1:0]    c_d0, c_d1;
  logic [LANES-1:0] c_m0, c_m1;

  burst_sram_wr_capture #(.AW(AW), .DW(DW), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .ph(ph), .wr_sel_n(wr_sel_n), .addr(addr),
    .wdata(wdata), .lane_we_n(lane_we_n), .commit(commit), .c_addr(c_addr),
    .c_d0(c_d0), .c_m0(c_m0), .c_d1(c_d1), .c_m1(c_m1)
  );

  logic [DW-1:0]    bank_wd [2];
  logic [LANES-1:0] bank_wm [2];
  logic [DW-1:0]    bank_rd [2];

  assign bank_wd[0] = c_d0;
  assign bank_wm[0] = c_m0;
  assign bank_wd[1] = c_d1;
  assign bank_wm[1] = c_m1;

  for (genvar h = 0; h < 2; h++) begin : g_half
    burst_sram_bank #(.AW(AW), .DW(DW), .LANES(LANES)) u_bank (
      .clk(clk), .we(commit), .waddr(c_addr), .wdata(bank_wd[h]),
      .wmask_n(bank_wm[h]), .raddr(raddr), .rdata(bank_rd[h])
    );
  end

  burst_sram_rd_pipe #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .ph(ph), .rd_sel_n(rd_sel_n), .addr(addr),
    .raddr(raddr), .even_q(bank_rd[0]), .odd_q(bank_rd[1]),
    .q(q), .q_vld(q_vld)
  );
endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int AW = 3, DW = 36, LANES = 4, NP = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_sel_n = 1'b1, rd_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [LANES-1:0] lane_we_n = '1;
  logic [DW-1:0] q;
  logic q_vld, half;

  burst_sram #(.AW(AW), .DW(DW), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .wr_sel_n(wr_sel_n), .rd_sel_n(rd_sel_n),
    .addr(addr), .wdata(wdata), .lane_we_n(lane_we_n),
    .q(q), .q_vld(q_vld), .half(half)
  );

  always #4 clk = ~clk;  // 125 MHz

  int vecs = 0, errs = 0, edge_n = 0;
  logic [DW-1:0] ref_e [NP];
  logic [DW-1:0] ref_o [NP];
  logic [DW-1:0] exp_q [int];

  always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d,
                                          logic [LANES-1:0] m);
    logic [DW-1:0] r = old;
    for (int l = 0; l < LANES; l++) if (!m[l]) r[l*9 +: 9] = d[l*9 +: 9];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(int p, int b, int s);
    return DW'(p + 1) * 36'h0_9E37_79B9 ^ DW'(b) * 36'h5_5555_5555 ^ DW'(s) * 36'h0_0F0F_1234;
  endfunction

  // Output schedule check every half-cycle (R5, R6, R7, R9)
  always @(negedge clk) begin
    if (!rst_n) begin
      vecs++;
      if (q_vld !== 1'b0 || q !== '0 || half !== 1'b0) begin
        errs++;
        $display("FAIL R10 reset: q=%h vld=%b half=%b expected 0 0 0", q, q_vld, half);
      end
    end else if (edge_n > 0) begin
      vecs++;
      if (half !== edge_n[0]) begin
        errs++;
        $display("FAIL R9 edge %0d: half=%b expected %b", edge_n, half, edge_n[0]);
      end
      if (exp_q.exists(edge_n)) begin
        vecs++;
        if (q_vld !== 1'b1 || q !== exp_q[edge_n]) begin
          errs++;
          $display("FAIL R6 edge %0d: q=%h vld=%b expected %h vld 1", edge_n, q, q_vld, exp_q[edge_n]);
        end
      end else begin
        vecs++;
        if (q_vld !== 1'b0 || q !== '0) begin
          errs++;
          $display("FAIL R7 edge %0d: q=%h vld=%b expected 0 vld 0", edge_n, q, q_vld);
        end
      end
    end
  end

  // One interface cycle, starting at the negedge before a phase-A edge.
  task automatic cyc(input bit rd, input int ra, input bit wr, input int wa,
                     input logic [DW-1:0] d0, input logic [LANES-1:0] m0,
                     input logic [DW-1:0] d1, input logic [LANES-1:0] m1);
    int e = edge_n + 1;
    rd_sel_n = !rd; wr_sel_n = !wr; addr = AW'(ra); wdata = d0; lane_we_n = m0;
    if (wr) begin
      ref_e[wa] = merge(ref_e[wa], d0, m0);
      ref_o[wa] = merge(ref_o[wa], d1, m1);
    end
    if (rd) begin
      exp_q[e + 3] = ref_e[ra];
      exp_q[e + 4] = ref_o[ra];
    end
    @(negedge clk);
    // Selects low at phase B must start nothing (R5, R1)
    rd_sel_n = 1'b0; wr_sel_n = 1'b0; addr = AW'(wa); wdata = d1; lane_we_n = m1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '1, '0, '1, '0);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin ref_e[p] = '0; ref_o[p] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R3, R2: fill every pair with full masks
    for (int p = 0; p < NP; p++) cyc(0, 0, 1, p, pat(p, 0, 0), '0, pat(p, 1, 0), '0);
    // R5, R6: back-to-back reads of every pair
    for (int p = 0; p < NP; p++) cyc(1, p, 0, 0, '1, '0, '1, '0);
    idle(3);
    // R4, R8: all masks per beat, same-cycle read of the written pair
    for (int p = 0; p < NP; p++)
      for (int m = 0; m < 16; m++)
        cyc(1, p, 1, p, pat(p, 0, m + 1), LANES'(m), pat(p, 1, m + 1), ~LANES'(m));
    idle(2);
    // R1: deselected write with live data, then read back unchanged
    for (int p = 0; p < NP; p++) cyc(1, p, 0, p, ~pat(p, 0, 99), '0, ~pat(p, 1, 99), '0);
    // R8: a write one cycle after the read is not visible to it
    cyc(1, 2, 0, 0, '1, '0, '1, '0);
    cyc(0, 0, 1, 2, pat(7, 0, 50), '0, pat(7, 1, 50), '0);
    cyc(1, 2, 0, 0, '1, '0, '1, '0);
    // R7: isolated reads with gaps
    cyc(1, 5, 0, 0, '1, '0, '1, '0);
    idle(1);
    cyc(1, 6, 0, 0, '1, '0, '1, '0);
    idle(4);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL R6 watchdog expired: actual running, expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule